// File: doc/BRIEF.md
# Pixel Buffer Refill Request Controller

This block keeps a display pixel FIFO of 32-bit longwords topped up. It tracks how many longwords the FIFO holds. When that count falls to a programmed trigger mark, it raises a request towards a memory-side DMA master. It then accepts incoming longwords on cycles where the master acknowledges, and stores them in order. The pixel side drains them through a read port with a registered data output.

Each refill burst ends by one of two rules, picked at run time by a mode bit. In fixed mode, every burst delivers exactly the high-mark number of longwords. In dynamic mode, the burst runs until the FIFO's free space has shrunk to the high mark minus two. Some settings are illegal: in fixed mode the high mark must exceed the trigger mark, and in dynamic mode the high mark must be at least 3. An illegal setting latches an error flag that only reset clears, and requests are held off while the flag is set.

Top module: `pixbuf_refill_ctrl`

## Requirements
- R1: After reset dma_req is 0, cfg_err is 0 and the FIFO is empty, so a read request produces no rd_valid.
- R2: With en high, cfg_err low and a legal setting, dma_req rises one clock after the first cycle in which the FIFO count is less than or equal to cfg_tm. It does not rise while the count is above cfg_tm.
- R3: A longword on wr_data is stored only on a clock where dma_req and wr_ack are both high and the FIFO is not full. wr_ack while dma_req is low stores nothing.
- R4: With cfg_fixed = 1, each burst stores exactly cfg_hm longwords, and dma_req falls on the clock that stores the last of them.
- R5: With cfg_fixed = 0, dma_req falls on the clock at which the FIFO's free slot count (32 minus count) becomes equal to cfg_hm minus 2.
- R6: Once raised, dma_req stays high until its burst-end condition is met. After the end, no new request is raised while the count is above cfg_tm.
- R7: If, while en is high, cfg_fixed = 1 with cfg_hm <= cfg_tm, or cfg_fixed = 0 with cfg_hm < 3, then cfg_err goes high on the next clock. It stays high until reset, and dma_req is held low while it is high.
- R8: Longwords leave on rd_data in the order they were stored, with rd_valid high the clock after an accepted read. A read and a write in the same clock both take effect.
- R9: While en is low, no new request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows new requests and the configuration check |
| cfg_fixed | input | 1 | Burst rule: 1 fixed length, 0 dynamic |
| cfg_hm | input | 5 | High mark |
| cfg_tm | input | 5 | Trigger mark (FIFO count that starts a request) |
| wr_data | input | 32 | Longword from the memory side |
| wr_ack | input | 1 | Memory side delivers wr_data this clock |
| dma_req | output | 1 | Refill request, registered |
| rd_en | input | 1 | Pixel side takes one longword |
| rd_data | output | 32 | Longword read, registered |
| rd_valid | output | 1 | rd_data holds a longword read on the previous clock |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The assertions check the following on every cycle:
- the FIFO count never leaves the range 0 to 32;
- a request only rises from a count at or below the trigger mark;
- a fixed-mode burst never counts past the high mark;
- a dynamic burst only ends at or below the free-space target;
- the error flag never clears, and the request is low whenever it is set.

Only the bench scenarios can show the exact burst lengths under both typical settings, that is 16 longwords in fixed mode and a stop at 30 held in dynamic mode. The same applies to the exact clock at which a request rises, in-order delivery while reads and writes overlap, and that an acknowledge outside a burst or a low enable has no effect.

// File: rtl/pixbuf_pkg.sv
package pixbuf_pkg;
  localparam int MARK_W = 5;

  typedef struct packed {
    logic              fixed;
    logic [MARK_W-1:0] hm;
    logic [MARK_W-1:0] tm;
  } refill_cfg_t;
endpackage

// File: rtl/pixbuf_fifo.sv
module pixbuf_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              wr_fire,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  level_next
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic              rd_fire;

  assign wr_fire = wr_req && (level != LVL_W'(DEPTH));
  assign rd_fire = rd_req && (level != '0);

  always_comb begin
    level_next = level;
    if (wr_fire && !rd_fire) level_next = level + 1'b1;
    else if (rd_fire && !wr_fire) level_next = level - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_fire) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      level    <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_fire) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_fire) rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      level    <= level_next;
      rd_valid <= rd_fire;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> (level <= LVL_W'(1))); // R8
endmodule

// File: rtl/pixbuf_cfg_check.sv
module pixbuf_cfg_check
  import pixbuf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  refill_cfg_t cfg,
  output logic        err_next,
  output logic        cfg_err
);
  logic bad;

  always_comb begin
    if (cfg.fixed) bad = (cfg.hm <= cfg.tm);
    else           bad = (cfg.hm < MARK_W'(3));
  end

  assign err_next = cfg_err || (en && bad);

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= err_next;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R7
endmodule

// File: rtl/pixbuf_burst_ctrl.sv
module pixbuf_burst_ctrl
  import pixbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  refill_cfg_t      cfg,
  input  logic             err_next,
  input  logic             cfg_err,
  input  logic             wr_fire,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] level_next,
  output logic             dma_req
);
  logic [MARK_W-1:0] beats_q, beats_n;
  logic              req_n;
  logic [LVL_W-1:0]  free_next, free_now, dyn_goal;

  assign free_next = LVL_W'(DEPTH) - level_next;
  assign free_now  = LVL_W'(DEPTH) - level;
  assign dyn_goal  = LVL_W'(cfg.hm) - LVL_W'(2);

  always_comb begin
    req_n   = dma_req;
    beats_n = beats_q;
    if (dma_req) begin
      if (wr_fire) beats_n = beats_q + 1'b1;
      if (cfg.fixed) begin
        if (wr_fire && (beats_q + 1'b1 == cfg.hm)) begin
          req_n   = 1'b0;
          beats_n = '0;
        end
      end else if (free_next <= dyn_goal) begin
        req_n   = 1'b0;
        beats_n = '0;
      end
    end else if (en && (level <= LVL_W'(cfg.tm))) begin
      req_n   = 1'b1;
      beats_n = '0;
    end
    if (err_next) req_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_req <= 1'b0;
      beats_q <= '0;
    end else begin
      dma_req <= req_n;
      beats_q <= beats_n;
    end
  end

  AST_REQ_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> ($past(level) <= LVL_W'($past(cfg.tm)))); // R2
  AST_NO_REQ_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !dma_req); // R7
  AST_FIXED_BOUND: assert property (@(posedge clk) disable iff (rst)
    (dma_req && cfg.fixed && !cfg_err) |-> (beats_q < cfg.hm)); // R4
  AST_DYN_END: assert property (@(posedge clk) disable iff (rst)
    ($fell(dma_req) && !cfg_err && !cfg.fixed) |-> (free_now <= dyn_goal)); // R5
endmodule

// File: rtl/pixbuf_refill_ctrl.sv
module pixbuf_refill_ctrl
  import pixbuf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cfg_fixed,
  input  logic [MARK_W-1:0] cfg_hm,
  input  logic [MARK_W-1:0] cfg_tm,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              dma_req,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              cfg_err
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  refill_cfg_t      cfg;
  logic             wr_fire, err_next;
  logic [LVL_W-1:0] level, level_next;

  assign cfg = '{fixed: cfg_fixed, hm: cfg_hm, tm: cfg_tm};

  pixbuf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_req(dma_req && wr_ack), .wr_data(wr_data), .rd_req(rd_en),
    .wr_fire(wr_fire), .rd_data(rd_data), .rd_valid(rd_valid),
    .level(level), .level_next(level_next)
  );

  pixbuf_cfg_check u_cfg (
    .clk(clk), .rst(rst), .en(en), .cfg(cfg),
    .err_next(err_next), .cfg_err(cfg_err)
  );

  pixbuf_burst_ctrl #(.DEPTH(DEPTH)) u_burst (
    .clk(clk), .rst(rst), .en(en), .cfg(cfg),
    .err_next(err_next), .cfg_err(cfg_err), .wr_fire(wr_fire),
    .level(level), .level_next(level_next), .dma_req(dma_req)
  );
endmodule

// File: tb/pixbuf_refill_ctrl_bench.sv
module pixbuf_refill_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        cfg_fixed = 1'b1;
  logic [4:0]  cfg_hm = 5'd16;
  logic [4:0]  cfg_tm = 5'd4;
  logic [31:0] wr_data = '0;
  logic        wr_ack = 1'b0;
  logic        rd_en = 1'b0;
  logic        dma_req, rd_valid, cfg_err;
  logic [31:0] rd_data;

  int total = 0;
  int bad = 0;
  int mcnt = 0;
  int last_w = 0;
  int cycles = 0;
  logic [31:0] seq = 32'h1000_0000;
  logic [31:0] expq[$];

  always #4 clk = ~clk;

  pixbuf_refill_ctrl u_pixbuf_refill_ctrl (
    .clk(clk), .rst(rst), .en(en), .cfg_fixed(cfg_fixed), .cfg_hm(cfg_hm),
    .cfg_tm(cfg_tm), .wr_data(wr_data), .wr_ack(wr_ack), .dma_req(dma_req),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // One clock: entered and left at a falling edge.
  task automatic step(input bit ack_v, input bit rd_v);
    bit aw, ar;
    wr_ack  = ack_v;
    rd_en   = rd_v;
    wr_data = seq;
    aw = dma_req && ack_v && (mcnt < 32);
    ar = rd_v && (mcnt > 0);
    if (aw) begin
      expq.push_back(seq);
      seq = seq + 32'h0000_0101;
    end
    @(posedge clk);
    mcnt   = mcnt + int'(aw) - int'(ar);
    last_w = int'(aw);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wr_ack = 1'b0;
    rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mcnt = 0;
    expq.delete();
  endtask

  task automatic burst(input bit with_rd, output int n);
    int guard = 0;
    bit t = 1'b0;
    n = 0;
    while (dma_req && guard < 200) begin
      step(1'b1, with_rd && t);
      t = ~t;
      n += last_w;
      guard++;
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (mcnt > 0 && guard < 100) begin
      step(1'b0, 1'b1);
      guard++;
    end
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check(expq.size() == 0, "R8 all stored words delivered", expq.size(), 0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R8 rd_valid with nothing stored", int'(rd_data), -1);
      end else begin
        logic [31:0] e;
        e = expq.pop_front();
        check(rd_data == e, "R8 read order", int'(rd_data), int'(e));
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        check(1'b0, "watchdog", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    int n;
    int got;
    do_reset();
    check(dma_req == 1'b0, "R1 dma_req after reset", int'(dma_req), 0);
    check(cfg_err == 1'b0, "R1 cfg_err after reset", int'(cfg_err), 0);

    // Enable low: no request, acks and reads do nothing
    got = 0;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b1);
      got += int'(rd_valid);
    end
    check(dma_req == 1'b0, "R9 no request while en low", int'(dma_req), 0);
    check(got == 0, "R1 empty FIFO gives no rd_valid", got, 0);
    check(mcnt == 0, "R3 ack without request stores nothing", mcnt, 0);

    // Fixed mode, HM=16 TM=4
    en = 1'b1;
    step(1'b0, 1'b0);
    check(dma_req == 1'b1, "R2 first request after enable", int'(dma_req), 1);
    burst(1'b0, n);
    check(n == 16, "R4 fixed burst length", n, 16);
    repeat (3) step(1'b1, 1'b0);
    check(dma_req == 1'b0, "R6 no re-request above TM", int'(dma_req), 0);
    check(mcnt == 16, "R3 acks after burst end ignored", mcnt, 16);
    repeat (12) step(1'b0, 1'b1);
    check(dma_req == 1'b0, "R2 no request before count reaches TM", int'(dma_req), 0);
    step(1'b0, 1'b0);
    check(dma_req == 1'b1, "R2 request one clock after count at TM", int'(dma_req), 1);
    repeat (3) step(1'b0, 1'b0);
    check(dma_req == 1'b1, "R6 request held without data", int'(dma_req), 1);
    burst(1'b1, n);
    check(n == 16, "R4 fixed burst length with reads", n, 16);
    drain();

    // Dynamic mode, HM=4 TM=8
    do_reset();
    cfg_fixed = 1'b0; cfg_hm = 5'd4; cfg_tm = 5'd8;
    step(1'b0, 1'b0);
    check(dma_req == 1'b1, "R2 dynamic first request", int'(dma_req), 1);
    burst(1'b0, n);
    check(mcnt == 30, "R5 dynamic end at free=HM-2", mcnt, 30);
    check(cfg_err == 1'b0, "R7 legal dynamic setting no error", int'(cfg_err), 0);
    repeat (22) step(1'b0, 1'b1);
    check(dma_req == 1'b0, "R6 no request above TM", int'(dma_req), 0);
    step(1'b0, 1'b0);
    check(dma_req == 1'b1, "R2 dynamic request at TM", int'(dma_req), 1);
    burst(1'b1, n);
    check(mcnt == 30, "R5 dynamic end with concurrent reads", mcnt, 30);
    drain();

    // Illegal dynamic setting, then stickiness
    do_reset();
    en = 1'b0;
    cfg_fixed = 1'b0; cfg_hm = 5'd2; cfg_tm = 5'd1;
    step(1'b0, 1'b0);
    en = 1'b1;
    step(1'b0, 1'b0);
    check(cfg_err == 1'b1, "R7 dynamic HM<3 flags error", int'(cfg_err), 1);
    check(dma_req == 1'b0, "R7 no request on error", int'(dma_req), 0);
    cfg_fixed = 1'b1; cfg_hm = 5'd16; cfg_tm = 5'd4;
    repeat (3) step(1'b1, 1'b0);
    check(cfg_err == 1'b1, "R7 error sticky", int'(cfg_err), 1);
    check(dma_req == 1'b0, "R7 request held off", int'(dma_req), 0);

    // Illegal fixed setting HM == TM
    do_reset();
    check(cfg_err == 1'b0, "R1 reset clears error", int'(cfg_err), 0);
    cfg_fixed = 1'b1; cfg_hm = 5'd4; cfg_tm = 5'd4;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check(cfg_err == 1'b1, "R7 fixed HM<=TM flags error", int'(cfg_err), 1);
    check(dma_req == 1'b0, "R7 fixed error no request", int'(dma_req), 0);

    finish_run();
  end
endmodule